// File: doc/BRIEF.md
# HMAC Command Sequencer

This block is the control state machine in front of a keyed SHA-256 hashing engine. Software drives it through a small register window. It opens a session, writes a purpose code and a key index, and confirms the setup. The block then looks up the purpose tied to the chosen key and raises an error flag when the two differ. While the error flag is set, no hashing is allowed.

With a valid setup, software fills a 16-word message buffer and issues block commands. Each command raises a request to the compression engine, and the request stays high until the engine answers. The last step of a message names how it ends:
- the engine applies the padding itself,
- software supplies an already padded final block, or
- the previous block already closed the message, so no padding step is needed.

The 8-word digest can then be read from the result window. A release command wipes the digest and returns the block to idle. Two separate strobes tell downstream consumers to drop a result they were given earlier. Commands that arrive in the wrong phase are ignored.

Top module: `hmac_cmd_seq`

## Requirements
- R1: After reset, the busy bit (0x6C bit 0) and the error bit (0x68 bit 0) read 0, the result window reads 0, and the version word at 0x1FC reads the 30-bit value 538969624.
- R2: A write to 0x40 while idle makes busy read 1. Any command written outside the phase that accepts it changes nothing: busy, the engine request and the phase all stay as they were.
- R3: A write to 0x4C in the configuration phase latches the error bit. The bit is 0 when the 4-bit purpose written at 0x44 equals entry k of the key-purpose table, and 1 otherwise. Entry k sits at bits [4k+3:4k], and k is the 3-bit key index written at 0x48.
- R4: While the error bit is 1, block commands never raise the engine request. A release write to 0x5C returns the block to idle.
- R5: A write to 0x50 after a clean setup raises the engine request with the first flag at 1 and pad code 00. Message word i, written at byte offset 0x80+4i, appears at eng_block bits [32i+31:32i].
- R6: A write to 0x54 after a completed block raises the request with the first flag at 0 and pad code 00.
- R7: After a completed block, a write to 0x58 raises a final request with pad code 01 (engine pads), and a write to 0xF0 raises a final request with pad code 10 (software padded).
- R8: After a completed block, a write to 0xF4 enters the result phase without any engine request. The digest of the last block is then kept.
- R9: While the request is high, writes to the message buffer are dropped and eng_block stays stable.
- R10: The result window reads 0 until the result phase is entered. In the result phase, digest word j is read at 0xC0+4j and comes from eng_digest bits [32j+31:32j].
- R11: In the result phase, a write to 0x5C returns the block to idle. Busy then reads 0 and the result window reads 0 again.
- R12: A write to 0x60 pulses inv_a high for one cycle, and a write to 0x64 pulses inv_b, in any phase.
- R13: Once raised, the request holds until eng_done. It is low in the cycle after eng_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 9 | Byte offset into the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| key_purposes | input | 32 | Purpose code of each key, 4 bits per key |
| eng_req | output | 1 | Request to the compression engine |
| eng_first | output | 1 | Request is the first block of a message |
| eng_pad | output | 2 | Final padding code: 00 none, 01 engine pads, 10 software padded |
| eng_block | output | 512 | Message buffer contents |
| eng_done | input | 1 | Engine finished the current request |
| eng_digest | input | 256 | Digest returned with eng_done |
| inv_a | output | 1 | Invalidate pulse to the first consumer |
| inv_b | output | 1 | Invalidate pulse to the second consumer |

## Verification
The bench runs random sessions with random key tables, block counts and ending modes. Every session is scored against digests computed from the words the bench itself wrote.

Directed cases target the following faults:
- Commands issued in the wrong phase: a design that accepts them would start the engine from idle or before setup, or release a session in mid-flight.
- A purpose mismatch: a design that ignores it would hash with the wrong key.
- A message write landing while the request is high: a design that lets it through would corrupt the block the engine is reading.
- Result reads before the final phase and after release: a design that fails here would leak a stale digest.

// File: rtl/hmac_cmd_seq.sv
`timescale 1ns/1ps
module hmac_cmd_seq #(
  parameter int AW        = 9,
  parameter int DW        = 32,
  parameter int MSG_WORDS = 16,
  parameter int RES_WORDS = 8,
  parameter int KEYS      = 8,
  parameter int PW        = 4,
  parameter logic [29:0] VERSION = 30'd538969624
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_we,
  input  logic [AW-1:0]             bus_addr,
  input  logic [DW-1:0]             bus_wdata,
  output logic [DW-1:0]             bus_rdata,
  input  logic [KEYS*PW-1:0]        key_purposes,
  output logic                      eng_req,
  output logic                      eng_first,
  output logic [1:0]                eng_pad,
  output logic [MSG_WORDS*DW-1:0]   eng_block,
  input  logic                      eng_done,
  input  logic [RES_WORDS*DW-1:0]   eng_digest,
  output logic                      inv_a,
  output logic                      inv_b
);
  localparam int KW   = $clog2(KEYS);
  localparam int MIW  = $clog2(MSG_WORDS);
  localparam int RIW  = $clog2(RES_WORDS);
  localparam int MSG_BYTES = MSG_WORDS * DW / 8;
  localparam int RES_BYTES = RES_WORDS * DW / 8;
  localparam logic [AW-1:0] A_START = AW'('h040);
  localparam logic [AW-1:0] A_PURP  = AW'('h044);
  localparam logic [AW-1:0] A_KEY   = AW'('h048);
  localparam logic [AW-1:0] A_CONF  = AW'('h04C);
  localparam logic [AW-1:0] A_FIRST = AW'('h050);
  localparam logic [AW-1:0] A_CONT  = AW'('h054);
  localparam logic [AW-1:0] A_HWPAD = AW'('h058);
  localparam logic [AW-1:0] A_REL   = AW'('h05C);
  localparam logic [AW-1:0] A_INVA  = AW'('h060);
  localparam logic [AW-1:0] A_INVB  = AW'('h064);
  localparam logic [AW-1:0] A_ERR   = AW'('h068);
  localparam logic [AW-1:0] A_BUSY  = AW'('h06C);
  localparam logic [AW-1:0] A_MSG   = AW'('h080);
  localparam logic [AW-1:0] A_RES   = AW'('h0C0);
  localparam logic [AW-1:0] A_SWPAD = AW'('h0F0);
  localparam logic [AW-1:0] A_NOPAD = AW'('h0F4);
  localparam logic [AW-1:0] A_VER   = AW'('h1FC);

  typedef enum logic [2:0] {S_IDLE, S_CFG, S_MSG1, S_RUN, S_MSGN, S_RES} st_t;

  st_t                    st;
  logic [PW-1:0]          purpose_q;
  logic [KW-1:0]          key_q;
  logic                   err_q, first_q, final_q;
  logic [1:0]             pad_q;
  logic [DW-1:0]          msg_q [MSG_WORDS];
  logic [RES_WORDS*DW-1:0] res_q;
  logic                   inv_a_q, inv_b_q;

  function automatic logic hit(input logic [AW-1:0] off);
    return bus_we && (bus_addr == off);
  endfunction

  wire in_msg = (bus_addr >= A_MSG) && (bus_addr < A_MSG + AW'(MSG_BYTES));
  wire in_res = (bus_addr >= A_RES) && (bus_addr < A_RES + AW'(RES_BYTES));
  wire [MIW-1:0] msg_idx = bus_addr[2 +: MIW];
  wire [RIW-1:0] res_idx = bus_addr[2 +: RIW];
  wire [PW-1:0] key_purpose = key_purposes[key_q*PW +: PW];
  wire busy   = (st != S_IDLE);
  wire res_ok = (st == S_RES);
  wire msg_wr = bus_we && in_msg && (st != S_RUN);

  assign eng_req   = (st == S_RUN);
  assign eng_first = first_q;
  assign eng_pad   = pad_q;
  assign inv_a     = inv_a_q;
  assign inv_b     = inv_b_q;

  for (genvar i = 0; i < MSG_WORDS; i++) begin : g_pack
    assign eng_block[i*DW +: DW] = msg_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MSG_WORDS; i++) msg_q[i] <= '0;
    end else if (msg_wr) begin
      msg_q[msg_idx] <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inv_a_q <= 1'b0;
      inv_b_q <= 1'b0;
    end else begin
      inv_a_q <= hit(A_INVA);
      inv_b_q <= hit(A_INVB);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      purpose_q <= '0;
      key_q     <= '0;
      err_q     <= 1'b0;
      first_q   <= 1'b0;
      final_q   <= 1'b0;
      pad_q     <= 2'b00;
      res_q     <= '0;
    end else begin
      case (st)
        S_IDLE: if (hit(A_START)) st <= S_CFG;
        S_CFG: begin
          if (hit(A_PURP)) purpose_q <= bus_wdata[PW-1:0];
          if (hit(A_KEY))  key_q     <= bus_wdata[KW-1:0];
          if (hit(A_CONF)) begin
            err_q <= (key_purpose != purpose_q);
            st    <= S_MSG1;
          end
        end
        S_MSG1: begin
          if (err_q && hit(A_REL)) begin
            err_q <= 1'b0;
            st    <= S_IDLE;
          end else if (!err_q && hit(A_FIRST)) begin
            first_q <= 1'b1;
            pad_q   <= 2'b00;
            final_q <= 1'b0;
            st      <= S_RUN;
          end
        end
        S_RUN: if (eng_done) begin
          res_q <= eng_digest;
          st    <= final_q ? S_RES : S_MSGN;
        end
        S_MSGN: begin
          if (hit(A_CONT)) begin
            first_q <= 1'b0; pad_q <= 2'b00; final_q <= 1'b0; st <= S_RUN;
          end else if (hit(A_HWPAD)) begin
            first_q <= 1'b0; pad_q <= 2'b01; final_q <= 1'b1; st <= S_RUN;
          end else if (hit(A_SWPAD)) begin
            first_q <= 1'b0; pad_q <= 2'b10; final_q <= 1'b1; st <= S_RUN;
          end else if (hit(A_NOPAD)) begin
            st <= S_RES;
          end
        end
        S_RES: if (hit(A_REL)) begin
          res_q   <= '0;
          first_q <= 1'b0;
          pad_q   <= 2'b00;
          final_q <= 1'b0;
          st      <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_ERR)       bus_rdata[0] = err_q;
    else if (bus_addr == A_BUSY) bus_rdata[0] = busy;
    else if (bus_addr == A_VER)  bus_rdata[29:0] = VERSION;
    else if (in_res && res_ok)   bus_rdata = res_q[res_idx*DW +: DW];
  end
endmodule

// File: rtl/hmac_cmd_seq_chk.sv
`timescale 1ns/1ps
module hmac_cmd_seq_chk #(
  parameter int AW = 9,
  parameter int BW = 512
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic          eng_req,
  input logic          eng_done,
  input logic          eng_first,
  input logic [1:0]    eng_pad,
  input logic [BW-1:0] eng_block,
  input logic          inv_a,
  input logic          inv_b,
  input logic          busy,
  input logic          err
);
  assert_req_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req && !eng_done |=> eng_req);
  assert_req_drop_R13: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req && eng_done |=> !eng_req);
  assert_err_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !eng_req);
  assert_block_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req && $past(eng_req) |-> $stable(eng_block));
  assert_first_nopad_R5: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req && eng_first |-> eng_pad == 2'b00);
  assert_req_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req |-> busy);
  assert_inv_a_src_R12: assert property (@(posedge clk) disable iff (!rst_n)
    inv_a |-> $past(bus_we && bus_addr == AW'('h060)));
  assert_inv_b_src_R12: assert property (@(posedge clk) disable iff (!rst_n)
    inv_b |-> $past(bus_we && bus_addr == AW'('h064)));
endmodule

bind hmac_cmd_seq hmac_cmd_seq_chk #(.AW(AW), .BW(MSG_WORDS*DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .eng_req(eng_req), .eng_done(eng_done), .eng_first(eng_first),
  .eng_pad(eng_pad), .eng_block(eng_block), .inv_a(inv_a), .inv_b(inv_b),
  .busy(busy), .err(err_q)
);

// File: tb/hmac_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module hmac_cmd_seq_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_we = 1'b0;
  logic [8:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic [31:0]  tbl = '0;
  logic         eng_req, eng_first, eng_done = 1'b0, inv_a, inv_b;
  logic [1:0]   eng_pad;
  logic [511:0] eng_block;
  logic [255:0] eng_digest = '0;

  int errors = 0, checks = 0, stub_cnt = 0;
  bit finished = 0;
  logic [31:0] m [16];
  logic [31:0] rv;
  logic [255:0] exp_dig;

  always #5 clk = ~clk;

  hmac_cmd_seq dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .key_purposes(tbl),
    .eng_req(eng_req), .eng_first(eng_first), .eng_pad(eng_pad),
    .eng_block(eng_block), .eng_done(eng_done), .eng_digest(eng_digest),
    .inv_a(inv_a), .inv_b(inv_b)
  );

  function automatic logic [255:0] dig(input logic [511:0] blk, input logic f, input logic [1:0] pad);
    logic [31:0] fold = '0;
    logic [255:0] d;
    for (int i = 0; i < 16; i++) fold ^= blk[32*i +: 32];
    for (int j = 0; j < 8; j++) d[32*j +: 32] = fold ^ (32'h9E3779B9 * (j + 1)) ^ {29'b0, f, pad};
    return d;
  endfunction

  function automatic logic [511:0] pack();
    logic [511:0] b;
    for (int i = 0; i < 16; i++) b[32*i +: 32] = m[i];
    return b;
  endfunction

  always @(posedge clk) begin
    eng_done <= 1'b0;
    if (eng_req && !eng_done) begin
      if (stub_cnt == 4) begin
        eng_done   <= 1'b1;
        eng_digest <= dig(eng_block, eng_first, eng_pad);
        stub_cnt   <= 0;
      end else stub_cnt <= stub_cnt + 1;
    end
  end

  task automatic ck(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_done();
    while (eng_req) @(negedge clk);
  endtask

  task automatic fill();
    for (int i = 0; i < 16; i++) begin
      m[i] = $urandom;
      wr(9'h080 + 9'(4 * i), m[i]);
    end
  endtask

  task automatic check_result(input string tag);
    for (int j = 0; j < 8; j++) begin
      rd(9'h0C0 + 9'(4 * j), rv);
      ck(tag, rv, exp_dig[32*j +: 32]);
    end
  endtask

  task automatic session(input int mode, input int nb, input bit bad);
    logic [3:0] p = 4'($urandom);
    logic [2:0] k = 3'($urandom);
    tbl = $urandom;
    tbl[4*k +: 4] = bad ? ~p : p;
    wr(9'h040, 0);
    rd(9'h06C, rv); ck("R2 busy after start", rv, 1);
    wr(9'h044, {28'($urandom), p});
    wr(9'h048, {29'($urandom), k});
    wr(9'h04C, 1);
    rd(9'h068, rv); ck("R3 error bit", rv, {31'b0, bad});
    if (bad) begin
      fill();
      wr(9'h050, 1);
      ck("R4 no request on error", {31'b0, eng_req}, 0);
      wr(9'h05C, 1);
      rd(9'h06C, rv); ck("R4 release from error", rv, 0);
      return;
    end
    for (int b = 0; b < nb; b++) begin
      fill();
      wr(b == 0 ? 9'h050 : 9'h054, 1);
      ck(b == 0 ? "R5 request first" : "R6 request cont", {29'b0, eng_req, eng_pad}, 3'b100);
      ck(b == 0 ? "R5 first flag" : "R6 first flag", {31'b0, eng_first}, {31'b0, b == 0});
      ck("R5 block word map", eng_block[32*b +: 32], m[b]);
      if (b == 0) begin
        wr(9'h080, ~m[0]);
        ck("R9 write blocked", eng_block[31:0], m[0]);
      end
      exp_dig = dig(pack(), b == 0, 2'b00);
      wait_done();
      ck("R13 request dropped", {31'b0, eng_req}, 0);
    end
    rd(9'h0C0, rv); ck("R10 result hidden before end", rv, 0);
    case (mode)
      0: begin
        wr(9'h0F4, 1);
        ck("R8 no request", {31'b0, eng_req}, 0);
      end
      1: begin
        wr(9'h058, 1);
        ck("R7 hw pad request", {29'b0, eng_req, eng_pad}, 3'b101);
        exp_dig = dig(pack(), 1'b0, 2'b01);
        wait_done();
      end
      default: begin
        fill();
        wr(9'h0F0, 1);
        ck("R7 sw pad request", {29'b0, eng_req, eng_pad}, 3'b110);
        exp_dig = dig(pack(), 1'b0, 2'b10);
        wait_done();
      end
    endcase
    check_result(mode == 0 ? "R8 kept digest" : "R10 digest");
    wr(9'h050, 1);
    ck("R2 first ignored in result phase", {31'b0, eng_req}, 0);
    wr(9'h05C, 1);
    rd(9'h06C, rv); ck("R11 idle after release", rv, 0);
    rd(9'h0C0, rv); ck("R11 result cleared", rv, 0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(9'h06C, rv); ck("R1 busy reset", rv, 0);
    rd(9'h068, rv); ck("R1 error reset", rv, 0);
    rd(9'h1FC, rv); ck("R1 version", rv, 32'd538969624);
    rd(9'h0C0, rv); ck("R1 result reset", rv, 0);

    wr(9'h050, 1);
    ck("R2 first ignored idle", {31'b0, eng_req}, 0);
    rd(9'h06C, rv); ck("R2 idle kept", rv, 0);
    wr(9'h060, 1);
    ck("R12 inv_a pulse", {30'b0, inv_a, inv_b}, 2'b10);
    @(negedge clk);
    ck("R12 inv_a one cycle", {31'b0, inv_a}, 0);
    wr(9'h064, 1);
    ck("R12 inv_b pulse", {30'b0, inv_a, inv_b}, 2'b01);

    tbl = 32'h7654_3210;
    wr(9'h040, 0);
    wr(9'h050, 1);
    ck("R2 first ignored in config", {31'b0, eng_req}, 0);
    wr(9'h044, 5); wr(9'h048, 5); wr(9'h04C, 1);
    rd(9'h068, rv); ck("R3 matching key", rv, 0);
    wr(9'h054, 1);
    ck("R2 cont ignored before first", {31'b0, eng_req}, 0);
    wr(9'h05C, 1);
    rd(9'h06C, rv); ck("R2 release ignored mid-session", rv, 1);
    fill();
    wr(9'h050, 1);
    exp_dig = dig(pack(), 1'b1, 2'b00);
    wait_done();
    wr(9'h060, 1);
    ck("R12 inv_a mid-session", {31'b0, inv_a}, 1);
    wr(9'h0F4, 1);
    check_result("R8 one-block digest");
    wr(9'h05C, 1);
    rd(9'h06C, rv); ck("R11 idle", rv, 0);

    for (int s = 0; s < 24; s++)
      session(int'($urandom % 3), 1 + int'($urandom % 3), ($urandom % 4) == 0);
    session(1, 2, 1'b1);
    session(2, 1, 1'b0);

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule